// File: doc/BRIEF.md
# Sized Sub-Word Register-to-Flop Writer

This block executes a single move instruction. The instruction copies data from a 64-entry, 32-bit source register file into banks of destination configuration flops. One instruction field selects the transfer size: one byte lane, one half-word lane, a full word, or a burst of four words. A separate offset field places a byte or half-word write in its lane, and the byte enables leave the other lanes untouched. A burst reads four source registers that start at an aligned base. It writes them to four consecutive destination entries on four consecutive cycles and raises `busy` for as long as it still has beats to issue.

The block reads the source register file through a combinational read port: `src_addr` goes out and `src_data` comes back in the same cycle. The destination sees a write strobe, a bank number, a 10-bit entry index, a data word and a byte enable. The destination decides what each entry means. An instruction word presented while `busy` is low is accepted at the clock edge, and its first write appears in the following cycle.

Top module: `reg_flop_writer`

## Requirements
- R1: Only instruction words whose bits [31:24] equal 0x48 are acted on; any other opcode produces no write.
- R2: The destination bank comes from bits [21:20] when they hold 0, 1 or 2; when they hold 3 the bank comes from bits [17:16] instead.
- R3: Size code 1 in bits [23:22] writes the whole source word. The source index comes from bits [5:0], the destination index from bits [15:6], and the byte enable is 4'b1111. The write appears in the cycle after the instruction is accepted.
- R4: Size code 2 writes the low 16 bits of the source. Offset 0 in bits [19:18] places them in data [15:0] with enable 4'b0011. Offset 1 places them in data [31:16] with enable 4'b1100. Data lanes that are not enabled are zero.
- R5: Size code 2 with offset 2 or 3 produces no write.
- R6: Size code 3 writes the low 8 bits of the source into byte lane `offset`. The enable is 1<<offset, and the other data lanes are zero.
- R7: Size code 0 issues four full-word writes on four consecutive cycles. Beat k reads source index (bits[5:0] with the low two bits cleared)+k and writes destination index (bits[15:6]+k) modulo 1024, with enable 4'b1111 on every beat.
- R8: `busy` is high in the cycles carrying the first three beats of a burst and low otherwise. An instruction presented while `busy` is high is ignored.
- R9: After reset, `wr_valid` and `busy` are low until an instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Instruction word present |
| inst_word | input | 32 | Instruction word |
| busy | output | 1 | Burst in progress; new instructions are ignored |
| src_addr | output | 6 | Source register read index |
| src_data | input | 32 | Source register read data (same cycle) |
| wr_valid | output | 1 | Destination write strobe |
| wr_bank | output | 2 | Destination bank |
| wr_idx | output | 10 | Destination entry index |
| wr_data | output | 32 | Destination write data |
| wr_be | output | 4 | Per-byte write enable |

## Verification
The bench builds the block with its default parameters: a 32-bit word, and therefore four byte lanes. At that width every lane position of the byte and half-word sizes can be reached directly. The 10-bit destination index lets a burst that starts at entry 1022 show the wrap to entry 0. The 6-bit source index lets an unaligned source index show the base rounding down to a multiple of four.

// File: rtl/r2f_pkg.sv
package r2f_pkg;
    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W / 8;
    localparam int SRC_IDX_W = 6;
    localparam int DST_IDX_W = 10;
    localparam int BANK_W    = 2;
    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = $clog2(BURST_LEN);
    localparam logic [7:0] MOVE_OPC = 8'h48;

    typedef enum logic [1:0] {
        SZ_QUAD = 2'd0,
        SZ_WORD = 2'd1,
        SZ_HALF = 2'd2,
        SZ_BYTE = 2'd3
    } size_e;

    typedef struct packed {
        logic                 ok;
        size_e                size;
        logic [BANK_W-1:0]    bank;
        logic [1:0]           off;
        logic [DST_IDX_W-1:0] dst;
        logic [SRC_IDX_W-1:0] src;
    } dec_t;
endpackage

// File: rtl/r2f_decode.sv
module r2f_decode
    import r2f_pkg::*;
(
    input  logic [31:0] inst_word,
    output dec_t        dec
);
    always_comb begin
        logic [1:0] tsel;
        logic [1:0] ctx;
        tsel      = inst_word[21:20];
        ctx       = inst_word[17:16];
        dec.size  = size_e'(inst_word[23:22]);
        dec.off   = inst_word[19:18];
        dec.dst   = inst_word[15:6];
        dec.src   = inst_word[5:0];
        dec.bank  = (tsel == 2'd3) ? ctx : tsel;
        // half-word lanes beyond the word are rejected
        dec.ok    = (inst_word[31:24] == MOVE_OPC) &&
                    !((dec.size == SZ_HALF) && dec.off[1]);
    end
endmodule

// File: rtl/r2f_lane.sv
module r2f_lane
    import r2f_pkg::*;
(
    input  size_e             size,
    input  logic [1:0]        off,
    input  logic [WORD_W-1:0] src_data,
    output logic [WORD_W-1:0] data,
    output logic [LANES-1:0]  be
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic       en;
        logic [7:0] byte_v;
        always_comb begin
            case (size)
                SZ_HALF: begin
                    en     = ((i / 2) == int'(off[0]));
                    byte_v = src_data[8*(i%2) +: 8];
                end
                SZ_BYTE: begin
                    en     = (i == int'(off));
                    byte_v = src_data[7:0];
                end
                default: begin
                    en     = 1'b1;
                    byte_v = src_data[8*i +: 8];
                end
            endcase
        end
        assign be[i]          = en;
        assign data[8*i +: 8] = en ? byte_v : 8'h00;
    end
endmodule

// File: rtl/reg_flop_writer.sv
module reg_flop_writer
    import r2f_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inst_valid,
    input  logic [31:0]          inst_word,
    output logic                 busy,
    output logic [SRC_IDX_W-1:0] src_addr,
    input  logic [WORD_W-1:0]    src_data,
    output logic                 wr_valid,
    output logic [BANK_W-1:0]    wr_bank,
    output logic [DST_IDX_W-1:0] wr_idx,
    output logic [WORD_W-1:0]    wr_data,
    output logic [LANES-1:0]     wr_be
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    typedef struct packed {
        logic                 active;
        logic                 burst;
        logic [BEAT_W-1:0]    beat;
        size_e                size;
        logic [1:0]           off;
        logic [BANK_W-1:0]    bank;
        logic [DST_IDX_W-1:0] dst;
        logic [SRC_IDX_W-1:0] srcb;
    } st_t;

    dec_t dec;
    st_t  st_d, st_q;

    r2f_decode u_dec (
        .inst_word (inst_word),
        .dec       (dec)
    );

    assign busy = st_q.active && st_q.burst && (st_q.beat != LAST_BEAT);

    always_comb begin
        st_d = st_q;
        if (busy) begin
            st_d.beat = st_q.beat + 1'b1;
        end else begin
            st_d.active = 1'b0;
            if (inst_valid && dec.ok) begin
                st_d.active = 1'b1;
                st_d.burst  = (dec.size == SZ_QUAD);
                st_d.beat   = '0;
                st_d.size   = dec.size;
                st_d.off    = dec.off;
                st_d.bank   = dec.bank;
                st_d.dst    = dec.dst;
                st_d.srcb   = (dec.size == SZ_QUAD) ?
                              {dec.src[SRC_IDX_W-1:BEAT_W], {BEAT_W{1'b0}}} : dec.src;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid = st_q.active;
    assign wr_bank  = st_q.bank;
    assign wr_idx   = st_q.dst + DST_IDX_W'(st_q.beat);
    assign src_addr = st_q.srcb + SRC_IDX_W'(st_q.beat);

    r2f_lane u_lane (
        .size     (st_q.size),
        .off      (st_q.off),
        .src_data (src_data),
        .data     (wr_data),
        .be       (wr_be)
    );

    // R7: every burst beat writes the whole word
    a_r7_burst_full_be: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && st_q.burst |-> wr_be == {LANES{1'b1}});

    // R7: burst source reads stay inside one aligned group
    a_r7_src_group: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> src_addr[SRC_IDX_W-1:BEAT_W] == $past(src_addr[SRC_IDX_W-1:BEAT_W]));

    // R6: a byte write enables exactly one lane
    a_r6_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && st_q.size == SZ_BYTE |-> $countones(wr_be) == 1);

    // R4 / R5: a half write only ever uses the low or high pair
    a_r5_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && st_q.size == SZ_HALF |-> (wr_be == 4'b0011 || wr_be == 4'b1100));

    // R8: busy is followed by the next beat at the next index
    a_r8_busy_next_beat: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> wr_valid && wr_idx == $past(wr_idx) + 1'b1);

    // R8: a burst runs to completion in one bank
    a_r8_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wr_bank));
endmodule

// File: tb/reg_flop_writer_tb.sv
module reg_flop_writer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inst_valid = 1'b0;
    logic [31:0] inst_word = '0;
    logic        busy;
    logic [5:0]  src_addr;
    logic [31:0] src_data;
    logic        wr_valid;
    logic [1:0]  wr_bank;
    logic [9:0]  wr_idx;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    string cur_tag = "R9";

    typedef struct {
        int          cyc;
        int          beat;
        logic [1:0]  bank;
        logic [9:0]  idx;
        logic [5:0]  src;
        int          size;
        int          off;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    reg_flop_writer u_dut (
        .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_word(inst_word),
        .busy(busy), .src_addr(src_addr), .src_data(src_data), .wr_valid(wr_valid),
        .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be)
    );

    function automatic logic [31:0] src_val(input logic [5:0] a);
        logic [7:0] b;
        b = {2'b00, a};
        return {b ^ 8'hC3, b + 8'h40, b + 8'h81, b ^ 8'h1E};
    endfunction
    assign src_data = src_val(src_addr);

    function automatic logic [31:0] enc(input int size, input int tsel, input int off,
                                        input int ctx, input int dst, input int src);
        return {8'h48, 2'(size), 2'(tsel), 2'(off), 2'(ctx), 10'(dst), 6'(src)};
    endfunction

    function automatic bit model_busy(input int c);
        foreach (exp_q[i])
            if (exp_q[i].cyc == c + 1 && exp_q[i].beat >= 1) return 1'b1;
        return 1'b0;
    endfunction

    // reference check every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit          have;
            exp_t        e;
            logic [31:0] ed;
            logic [3:0]  eb;
            logic [31:0] v;
            bit          eb_busy;
            string       tag;
            have = 1'b0;
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) void'(exp_q.pop_front());
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                e = exp_q.pop_front();
                have = 1'b1;
            end
            eb_busy = model_busy(cyc);
            tag = have ? e.tag : cur_tag;
            total++;
            if (!have) begin
                if (wr_valid !== 1'b0 || busy !== 1'b0) begin
                    bad++;
                    $display("FAIL %s cyc=%0d: wr_valid=%b busy=%b expected 0 0",
                             tag, cyc, wr_valid, busy);
                end
            end else begin
                v = src_val(e.src);
                case (e.size)
                    2: begin
                        eb = (e.off == 0) ? 4'b0011 : 4'b1100;
                        ed = (e.off == 0) ? {16'h0, v[15:0]} : {v[15:0], 16'h0};
                    end
                    3: begin
                        eb = 4'b0001 << e.off;
                        ed = {24'h0, v[7:0]} << (8 * e.off);
                    end
                    default: begin eb = 4'hF; ed = v; end
                endcase
                if ({wr_valid, busy, wr_bank, wr_idx, wr_data, wr_be} !==
                    {1'b1, eb_busy, e.bank, e.idx, ed, eb}) begin
                    bad++;
                    $display("FAIL %s cyc=%0d: got v=%b busy=%b bank=%0d idx=%0d data=%h be=%b expected v=1 busy=%b bank=%0d idx=%0d data=%h be=%b",
                             tag, cyc, wr_valid, busy, wr_bank, wr_idx, wr_data, wr_be,
                             eb_busy, e.bank, e.idx, ed, eb);
                end
            end
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    // present one word for one cycle and record what it should do
    task automatic issue(input logic [31:0] w, input string tag);
        @(negedge clk); #1;
        cur_tag    = tag;
        inst_valid = 1'b1;
        inst_word  = w;
        if (!model_busy(cyc) && w[31:24] == 8'h48 &&
            !(w[23:22] == 2'd2 && w[19:18] >= 2'd2)) begin
            int size = int'(w[23:22]);
            logic [1:0] bank = (w[21:20] == 2'd3) ? w[17:16] : w[21:20];
            int n = (size == 0) ? 4 : 1;
            for (int k = 0; k < n; k++) begin
                exp_t e;
                e.cyc  = cyc + 1 + k;
                e.beat = (size == 0) ? k : 0;
                e.bank = bank;
                e.idx  = w[15:6] + 10'(k);
                e.src  = (size == 0) ? ({w[5:2], 2'b00} + 6'(k)) : w[5:0];
                e.size = size;
                e.off  = int'(w[19:18]);
                e.tag  = (size == 0) ? "R7" : (size == 1) ? "R3" : (size == 2) ? "R4" : "R6";
                if (tag == "R2") e.tag = "R2";
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            cur_tag = tag;
            inst_valid = 1'b0;
            inst_word = 32'h0;
        end
    endtask

    bit timed_out = 1'b0;

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                #1 rst_n = 1'b1;
                idle(3, "R9");                       // R9 reset state
                issue(enc(1, 0, 0, 0, 17, 9), "R3"); // R3 word writes
                issue(enc(1, 1, 2, 1, 700, 63), "R3");
                idle(1, "R3");
                for (int t = 0; t < 3; t++) issue(enc(1, t, 0, 2, 40 + t, t), "R2");
                for (int c = 0; c < 4; c++) issue(enc(1, 3, 0, c, 50 + c, 20 + c), "R2");
                issue(enc(2, 0, 0, 0, 5, 11), "R4"); // R4 half low
                issue(enc(2, 2, 1, 0, 6, 12), "R4"); // R4 half high
                issue(enc(2, 0, 2, 0, 7, 13), "R5"); // R5 suppressed
                issue(enc(2, 1, 3, 0, 8, 14), "R5");
                idle(2, "R5");
                for (int o = 0; o < 4; o++) issue(enc(3, 1, o, 0, 90 + o, 30 + o), "R6");
                issue({8'h49, enc(1, 0, 0, 0, 3, 3)}[31:0] | 32'h4900_0000, "R1");
                issue(enc(1, 0, 0, 0, 3, 3) ^ 32'h0100_0000, "R1");  // opcode 0x49
                issue(enc(1, 0, 0, 0, 3, 3) ^ 32'hF000_0000, "R1");  // opcode 0xB8
                idle(2, "R1");
                issue(enc(0, 2, 0, 0, 1022, 6), "R7");                // R7 wrap, base 4
                issue(enc(1, 0, 0, 0, 200, 1), "R8");                 // R8 ignored while busy
                issue(enc(3, 0, 1, 0, 201, 2), "R8");
                issue(enc(0, 1, 0, 0, 300, 8), "R8");
                issue(enc(0, 3, 0, 3, 10, 41), "R7");                 // back-to-back burst
                idle(6, "R8");
                for (int r = 0; r < 300; r++) begin
                    logic [31:0] w = $urandom;
                    if (r % 7 != 0) w[31:24] = 8'h48;
                    if ($urandom % 3 == 0) idle(1, "R8");
                    else issue(w, "R8");
                end
                idle(6, "R8");
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule